// File: doc/BRIEF.md
# Submission Ring Producer Tracker

This block holds the producer-side bookkeeping for one descriptor ring whose depth is a power of two. Software asks it for a slot. It returns the slot index and a 2-bit generation tag, and software stamps the tag into the descriptor it writes there. The generation tag changes on every trip around the ring. A consumer reading the ring can therefore tell a fresh entry from one left over from the previous lap.

The tracker compares its producer index with a consumer index to report how many slots are free and whether the ring is empty. The consumer index moves when an acknowledge input carries a count. One slot is always kept unused, so a full ring and an empty ring never look the same.

A separate doorbell input posts a batch of written descriptors to a tail counter that the fetch engine watches. A doorbell with an illegal count does not move the tail. Instead it sets an error flag that stays set until reset.

Top module: `srp_ring_producer`

## Requirements
- R1: A synchronous active-high reset sets the producer index, consumer index, posted tail and generation tag to 0 and clears the doorbell error, so that free_slots reads DEPTH-1 and ring_empty reads 1.
- R2: alloc_idx always shows the slot the next grant returns. A granted request moves it to (alloc_idx+1) mod DEPTH on the following clock edge.
- R3: The generation tag is 2 bits. It steps by one modulo 4 on the same edge where the producer index wraps from DEPTH-1 to 0, so every slot reports the tag that was current when it was granted.
- R4: free_slots equals (consumer index - (producer index + 1)) AND (DEPTH-1).
- R5: ring_empty is 1 exactly when (consumer index - producer index) AND (DEPTH-1) is 0.
- R6: A request made while free_slots is 0 is refused. alloc_busy is 1 in that cycle, and neither the producer index nor the tag changes.
- R7: An acknowledge moves the consumer index to (consumer index + ack_count) AND (DEPTH-1). The count is 17 bits wide, so a count of DEPTH leaves the index unchanged.
- R8: A doorbell with a count from 1 to DEPTH inclusive moves tail_idx to (tail_idx + count) AND (DEPTH-1).
- R9: A doorbell with a count of 0 or more than DEPTH leaves tail_idx unchanged and sets db_err. db_err then stays 1 until reset, and later legal doorbells still move the tail.
- R10: When a request and an acknowledge arrive in the same cycle, the grant decision uses the free count from before the acknowledge, and both updates take effect on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Request one slot |
| alloc_idx | output | 16 | Slot index the next grant returns |
| alloc_gen | output | 2 | Generation tag for that slot |
| alloc_busy | output | 1 | Request refused because the ring is full |
| ack_valid | input | 1 | Consumer acknowledge strobe |
| ack_count | input | 17 | Number of slots acknowledged |
| cons_idx | output | 16 | Consumer index |
| free_slots | output | 16 | Slots that can still be granted |
| ring_empty | output | 1 | No slot outstanding |
| db_valid | input | 1 | Doorbell strobe |
| db_count | input | 17 | Number of descriptors posted |
| tail_idx | output | 16 | Posted tail seen by the engine |
| db_err | output | 1 | Sticky flag for an illegal doorbell count |

## Verification
The bench first fills the ring until requests are refused, which separates the off-by-one full condition from the empty condition. It then runs long streams of grants and acknowledges that wrap the producer several times; wrong tag timing or a missing mask shows up there. Doorbell counts of 0, 1, DEPTH and DEPTH+1, and acknowledge counts of DEPTH and above, probe the edges of the legal range. A random mix of all three inputs, with reset applied part way through, catches interactions that occur only when they land in the same cycle.

// File: rtl/srp_pkg.sv
package srp_pkg;

    localparam int IDX_W = 16;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [IDX_W:0]   cnt_t;
    typedef logic [1:0]       gen_t;

    typedef struct packed {
        idx_t idx;
        gen_t gen;
    } slot_t;

    function automatic idx_t wrap_add(idx_t base, cnt_t step, idx_t mask);
        cnt_t sum;
        sum = {1'b0, base} + step;
        return sum[IDX_W-1:0] & mask;
    endfunction

    function automatic idx_t ring_dist(idx_t ahead, idx_t behind, idx_t mask);
        return (ahead - behind) & mask;
    endfunction

endpackage

// File: rtl/srp_prod_ctr.sv
module srp_prod_ctr
    import srp_pkg::*;
#(
    parameter int LOG2_DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  grant,
    output slot_t slot
);
    localparam idx_t MASK = idx_t'((1 << LOG2_DEPTH) - 1);

    slot_t cur_q;
    idx_t  nxt_idx;

    always_comb begin
        nxt_idx = wrap_add(cur_q.idx, cnt_t'(1), MASK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else if (grant) begin
            cur_q.idx <= nxt_idx;
            if (nxt_idx == '0) begin
                cur_q.gen <= cur_q.gen + gen_t'(1);
            end
        end
    end

    assign slot = cur_q;
endmodule

// File: rtl/srp_cons_ctr.sv
module srp_cons_ctr
    import srp_pkg::*;
#(
    parameter int LOG2_DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ack_valid,
    input  cnt_t ack_count,
    output idx_t cons_idx
);
    localparam idx_t MASK = idx_t'((1 << LOG2_DEPTH) - 1);

    idx_t cons_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cons_q <= '0;
        end else if (ack_valid) begin
            cons_q <= wrap_add(cons_q, ack_count, MASK);
        end
    end

    assign cons_idx = cons_q;
endmodule

// File: rtl/srp_doorbell.sv
module srp_doorbell
    import srp_pkg::*;
#(
    parameter int LOG2_DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic db_valid,
    input  cnt_t db_count,
    output idx_t tail_idx,
    output logic db_err
);
    localparam idx_t MASK  = idx_t'((1 << LOG2_DEPTH) - 1);
    localparam cnt_t DEPTH = cnt_t'(1 << LOG2_DEPTH);

    idx_t tail_q;
    logic err_q;
    logic legal;

    always_comb begin
        legal = (db_count != '0) && (db_count <= DEPTH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tail_q <= '0;
            err_q  <= 1'b0;
        end else if (db_valid) begin
            if (legal) begin
                tail_q <= wrap_add(tail_q, db_count, MASK);
            end else begin
                err_q <= 1'b1;
            end
        end
    end

    assign tail_idx = tail_q;
    assign db_err   = err_q;
endmodule

// File: rtl/srp_ring_producer.sv
module srp_ring_producer
    import srp_pkg::*;
#(
    parameter int LOG2_DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 alloc_req,
    output logic [IDX_W-1:0]     alloc_idx,
    output logic [1:0]           alloc_gen,
    output logic                 alloc_busy,
    input  logic                 ack_valid,
    input  logic [IDX_W:0]       ack_count,
    output logic [IDX_W-1:0]     cons_idx,
    output logic [IDX_W-1:0]     free_slots,
    output logic                 ring_empty,
    input  logic                 db_valid,
    input  logic [IDX_W:0]       db_count,
    output logic [IDX_W-1:0]     tail_idx,
    output logic                 db_err
);
    localparam idx_t MASK = idx_t'((1 << LOG2_DEPTH) - 1);

    slot_t prod_slot;
    idx_t  cons_w;
    idx_t  free_w;
    logic  grant;

    always_comb begin
        free_w     = ring_dist(cons_w, prod_slot.idx + idx_t'(1), MASK);
        grant      = alloc_req && (free_w != '0);
        alloc_busy = alloc_req && (free_w == '0);
        ring_empty = (ring_dist(cons_w, prod_slot.idx, MASK) == '0);
    end

    srp_prod_ctr #(.LOG2_DEPTH(LOG2_DEPTH)) prod_i (
        .clk   (clk),
        .rst   (rst),
        .grant (grant),
        .slot  (prod_slot)
    );

    srp_cons_ctr #(.LOG2_DEPTH(LOG2_DEPTH)) cons_i (
        .clk       (clk),
        .rst       (rst),
        .ack_valid (ack_valid),
        .ack_count (ack_count),
        .cons_idx  (cons_w)
    );

    srp_doorbell #(.LOG2_DEPTH(LOG2_DEPTH)) bell_i (
        .clk      (clk),
        .rst      (rst),
        .db_valid (db_valid),
        .db_count (db_count),
        .tail_idx (tail_idx),
        .db_err   (db_err)
    );

    assign alloc_idx  = prod_slot.idx;
    assign alloc_gen  = prod_slot.gen;
    assign cons_idx   = cons_w;
    assign free_slots = free_w;
endmodule

// File: rtl/srp_checker.sv
module srp_checker
    import srp_pkg::*;
#(
    parameter int LOG2_DEPTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             alloc_req,
    input logic [IDX_W-1:0] alloc_idx,
    input logic [1:0]       alloc_gen,
    input logic             alloc_busy,
    input logic             ack_valid,
    input logic [IDX_W-1:0] cons_idx,
    input logic [IDX_W-1:0] free_slots,
    input logic             ring_empty,
    input logic             db_valid,
    input logic [IDX_W:0]   db_count,
    input logic [IDX_W-1:0] tail_idx,
    input logic             db_err
);
    localparam idx_t MASK  = idx_t'((1 << LOG2_DEPTH) - 1);
    localparam cnt_t DEPTH = cnt_t'(1 << LOG2_DEPTH);

    // R2
    alloc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc_req && !alloc_busy) |=> (alloc_idx == ((idx_t'($past(alloc_idx) + 16'd1)) & MASK)));

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        alloc_busy |=> ($stable(alloc_idx) && $stable(alloc_gen)));

    // R3
    gen_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc_gen != $past(alloc_gen)) |-> (alloc_idx == '0));

    // R5
    empty_free_chk: assert property (@(posedge clk) disable iff (rst)
        ring_empty |-> (free_slots == MASK));

    // R7
    cons_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ack_valid |=> $stable(cons_idx));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        db_err |=> db_err);

    // R9
    bad_bell_chk: assert property (@(posedge clk) disable iff (rst)
        (db_valid && ((db_count == '0) || (db_count > DEPTH))) |=> ($stable(tail_idx) && db_err));
endmodule

bind srp_ring_producer srp_checker #(.LOG2_DEPTH(LOG2_DEPTH)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .alloc_req  (alloc_req),
    .alloc_idx  (alloc_idx),
    .alloc_gen  (alloc_gen),
    .alloc_busy (alloc_busy),
    .ack_valid  (ack_valid),
    .cons_idx   (cons_idx),
    .free_slots (free_slots),
    .ring_empty (ring_empty),
    .db_valid   (db_valid),
    .db_count   (db_count),
    .tail_idx   (tail_idx),
    .db_err     (db_err)
);

// File: tb/srp_ring_producer_tb.sv
module srp_ring_producer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LOG2_DEPTH = 4;
    localparam int DEPTH      = 1 << LOG2_DEPTH;
    localparam int MASK       = DEPTH - 1;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst;
    logic        alloc_req;
    logic [15:0] alloc_idx;
    logic [1:0]  alloc_gen;
    logic        alloc_busy;
    logic        ack_valid;
    logic [16:0] ack_count;
    logic [15:0] cons_idx;
    logic [15:0] free_slots;
    logic        ring_empty;
    logic        db_valid;
    logic [16:0] db_count;
    logic [15:0] tail_idx;
    logic        db_err;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;

    // reference state
    int m_prod, m_cons, m_tail, m_gen;
    bit m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    srp_ring_producer #(.LOG2_DEPTH(LOG2_DEPTH)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .alloc_req  (alloc_req),
        .alloc_idx  (alloc_idx),
        .alloc_gen  (alloc_gen),
        .alloc_busy (alloc_busy),
        .ack_valid  (ack_valid),
        .ack_count  (ack_count),
        .cons_idx   (cons_idx),
        .free_slots (free_slots),
        .ring_empty (ring_empty),
        .db_valid   (db_valid),
        .db_count   (db_count),
        .tail_idx   (tail_idx),
        .db_err     (db_err)
    );

    task automatic chk(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            summary();
        end
    end

    // Drive one cycle at the falling edge, compare against the model, then
    // advance the model the way the next rising edge should.
    task automatic step(bit r, bit a, bit av, int ac, bit dv, int dc);
        int  e_free;
        bit  e_busy;
        @(negedge clk);
        rst       = r;
        alloc_req = a;
        ack_valid = av;
        ack_count = 17'(ac);
        db_valid  = dv;
        db_count  = 17'(dc);
        #1;
        e_free = (m_cons - (m_prod + 1)) & MASK;
        e_busy = a && (e_free == 0);
        chk("R2", "alloc_idx",  int'(alloc_idx),  m_prod);
        chk("R3", "alloc_gen",  int'(alloc_gen),  m_gen);
        chk("R4", "free_slots", int'(free_slots), e_free);
        chk("R5", "ring_empty", int'(ring_empty), (((m_cons - m_prod) & MASK) == 0) ? 1 : 0);
        chk("R6", "alloc_busy", int'(alloc_busy), int'(e_busy));
        chk("R7", "cons_idx",   int'(cons_idx),   m_cons);
        chk("R8", "tail_idx",   int'(tail_idx),   m_tail);
        chk("R9", "db_err",     int'(db_err),     int'(m_err));
        if (r) begin
            m_prod = 0; m_cons = 0; m_tail = 0; m_gen = 0; m_err = 0;
        end else begin
            // R10: grant decided on the free count before this cycle's ack
            if (a && e_free != 0) begin
                m_prod = (m_prod + 1) & MASK;
                if (m_prod == 0) m_gen = (m_gen + 1) & 3;
            end
            if (av) m_cons = (m_cons + ac) & MASK;
            if (dv) begin
                if (dc >= 1 && dc <= DEPTH) m_tail = (m_tail + dc) & MASK;
                else m_err = 1;
            end
        end
    endtask

    task automatic check_reset_state();
        @(negedge clk);
        #1;
        chk("R1", "alloc_idx",  int'(alloc_idx),  0);
        chk("R1", "alloc_gen",  int'(alloc_gen),  0);
        chk("R1", "cons_idx",   int'(cons_idx),   0);
        chk("R1", "tail_idx",   int'(tail_idx),   0);
        chk("R1", "db_err",     int'(db_err),     0);
        chk("R1", "free_slots", int'(free_slots), MASK);
        chk("R1", "ring_empty", int'(ring_empty), 1);
    endtask

    initial begin
        rst = 1'b1; alloc_req = 0; ack_valid = 0; ack_count = 0; db_valid = 0; db_count = 0;
        m_prod = 0; m_cons = 0; m_tail = 0; m_gen = 0; m_err = 0;
        @(posedge clk);
        @(posedge clk);
        step(1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        check_reset_state();

        // R2 R4: fill the ring; one slot stays unused
        for (int i = 0; i < MASK; i++) step(0, 1, 0, 0, 0, 0);
        // R6: full ring refuses requests
        step(0, 1, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0, 0);
        // R10: request and ack together while full: refused, ack applied
        step(0, 1, 1, 5, 0, 0);
        step(0, 1, 0, 0, 0, 0);
        // R7: ack of DEPTH leaves consumer unchanged, then larger counts
        step(0, 0, 1, DEPTH, 0, 0);
        step(0, 0, 1, DEPTH + 3, 0, 0);
        step(0, 0, 1, 7, 0, 0);

        // R3: steady streaming wraps the producer many times
        for (int i = 0; i < 200; i++) step(0, 1, 1, 1, 0, 0);
        for (int i = 0; i < 40; i++) step(0, 1, (i % 3) == 0, 2, 0, 0);

        // R8 R9: doorbell legal edges, then illegal counts
        step(0, 0, 0, 0, 1, 1);
        step(0, 0, 0, 0, 1, DEPTH);
        step(0, 0, 0, 0, 1, 5);
        step(0, 0, 0, 0, 1, DEPTH + 1);
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 1, 7);
        step(0, 0, 0, 0, 0, 0);

        // R1: reset clears the sticky error and all indices
        step(1, 0, 0, 0, 0, 0);
        check_reset_state();

        // mixed random traffic with an occasional reset
        for (int i = 0; i < 2000; i++) begin
            step(($urandom_range(0, 499) == 0),
                 $urandom_range(0, 3) != 0,
                 $urandom_range(0, 2) == 0,
                 int'($urandom_range(0, 4)),
                 $urandom_range(0, 5) == 0,
                 int'($urandom_range(0, DEPTH + 2)));
        end
        step(0, 0, 0, 0, 0, 0);
        summary();
    end
endmodule